// File: doc/BRIEF.md
# Receive Descriptor Ring Manager

This block steps through a circular list of two-word receive buffer descriptors held in memory on behalf of a network receive DMA engine. Software loads the word address of the list while receive is off, prepares the descriptors and then turns receive on. Each time a frame starts arriving, the manager reads the descriptor word at the current ring position. It checks that hardware owns the buffer and offers the buffer address to the payload mover.

When the mover reports that a buffer is complete, the manager writes a status word into the descriptor's second word. It then sets the ownership bit in the first word, which hands the buffer back to software, and moves to the next descriptor. If the frame continues, it fetches that next descriptor straight away. A buffer that ends in error is neither written nor advanced past, so the next frame reuses it.

The ring position is an 11-bit word count added to the base. It returns to zero after a descriptor whose wrap flag is set, and it rolls over on its own after 1024 descriptors. All memory traffic goes through a single request/acknowledge port that holds its request until acknowledged.

Top module: `rxd_ring_mgr`

## Requirements
- R1: After reset, `mem_req`, `buf_valid` and `bna` are low and `qptr` is 0.
- R2: A pulse on `base_wr` while `rx_en` is low loads the base, clears the ring count and makes `qptr` equal `{base_val, 2'b00}`. A pulse on `base_wr` while `rx_en` is high has no effect on `qptr`.
- R3: `frm_start` is ignored while `rx_en` is low. With `rx_en` high and the manager idle, it starts a read (`mem_we`=0) of the descriptor word at `qptr`.
- R4: If the fetched word has bit 0 set (software-owned), the manager offers no buffer and raises `bna` for exactly one cycle. It then waits for `rx_restart` and re-reads the same address.
- R5: If bit 0 of the fetched word is clear, `buf_valid` rises with `buf_addr` equal to the fetched word with bits 1:0 cleared. Both hold until `buf_done`, and no memory request is made while `buf_valid` is high.
- R6: On a completed buffer, the status word is written to `qptr`+4. Bit 15 marks end of frame and bit 14 marks start of frame, set only on the first buffer of a frame. Bits 13:12 carry `rx_offset` in normal mode, and bits 11:0 carry `buf_len[11:0]` on the end-of-frame buffer and 0 otherwise. All other bits are 0.
- R7: With `jumbo` high, status bits 13:12 carry `buf_len[13:12]` on the end-of-frame buffer and 0 on other buffers.
- R8: After the status write, the first descriptor word is written back to `qptr` with bit 0 set and all other bits unchanged.
- R9: After the write-back, `qptr` advances by 8 bytes, or returns to the base if the descriptor's bit 1 (wrap) was set.
- R10: Without any wrap flag, `qptr` returns to the base after 1024 descriptors.
- R11: A `buf_done` with `buf_err` high causes no memory write and leaves `qptr` unchanged. The frame is dropped, and the next frame's first status again carries start of frame.
- R12: After a buffer that is not end of frame, the next descriptor is fetched without a new `frm_start`.
- R13: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable |
| base_wr | input | 1 | Load pulse for the ring base |
| base_val | input | 30 | Ring base as a word address (byte address bits 31:2) |
| jumbo | input | 1 | Jumbo length mode |
| rx_offset | input | 2 | Byte offset reported in status |
| frm_start | input | 1 | Frame data has begun arriving |
| rx_restart | input | 1 | Retry after buffer-not-available |
| buf_valid | output | 1 | Buffer offered to the mover |
| buf_addr | output | 32 | Offered buffer byte address |
| buf_done | input | 1 | Mover finished the buffer |
| buf_eof | input | 1 | Buffer holds the end of the frame |
| buf_err | input | 1 | Reception into the buffer failed |
| buf_len | input | 14 | Frame length, FCS included |
| bna | output | 1 | Buffer-not-available pulse |
| qptr | output | 32 | Byte address of the current descriptor |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted/completed |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The embedded assertions check the following on every cycle:
- memory requests stay stable until acknowledged;
- `bna` lasts one cycle and only follows a read that returned a software-owned word;
- no memory request overlaps an offered buffer;
- an errored buffer leaves the ring position alone;
- a wrap step lands back on the base.

The status field layout, the ownership write-back data, 1024-entry rollover, jumbo length encoding and continuation across buffers depend on multi-frame sequences. Only the bench's scenarios can show these, compared against its cycle model and against the descriptor memory contents.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int DW       = 32;
  localparam int LEN_W    = 14;
  localparam int OWN_BIT  = 0;
  localparam int WRAP_BIT = 1;
  localparam int EOF_BIT  = 15;
  localparam int SOF_BIT  = 14;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_STALL,
    S_BUSY,
    S_WSTAT,
    S_WOWN
  } seq_e;
endpackage

// File: rtl/rxd_status_fmt.sv
module rxd_status_fmt
  import rxd_pkg::*;
(
  input  logic             sof,
  input  logic             eof,
  input  logic             jumbo,
  input  logic [1:0]       offset,
  input  logic [LEN_W-1:0] len,
  output logic [DW-1:0]    word
);
  always_comb begin
    word          = '0;
    word[EOF_BIT] = eof;
    word[SOF_BIT] = sof;
    if (jumbo) word[13:12] = eof ? len[13:12] : 2'b00;
    else       word[13:12] = offset;
    if (eof)   word[11:0]  = len[11:0];
  end
endmodule

// File: rtl/rxd_ring_ptr.sv
module rxd_ring_ptr #(
  parameter int CNT_W      = 11,
  parameter int DESC_WORDS = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic [29:0] load_val,
  input  logic        step,
  input  logic        wrap,
  output logic [31:0] desc_addr,
  output logic [31:0] stat_addr
);
  localparam logic [CNT_W-1:0] STEP_W = CNT_W'(DESC_WORDS);

  logic [29:0]      base_w;
  logic [CNT_W-1:0] cnt;
  logic [29:0]      cur_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_w <= '0;
      cnt    <= '0;
    end else if (load) begin
      base_w <= load_val;
      cnt    <= '0;
    end else if (step) begin
      cnt <= wrap ? '0 : cnt + STEP_W;
    end
  end

  assign cur_w     = base_w + 30'(cnt);
  assign desc_addr = {cur_w, 2'b00};
  assign stat_addr = {cur_w + 30'd1, 2'b00};

  // R9
  wrap_home_chk: assert property (@(posedge clk) disable iff (rst)
    (step && wrap && !load) |=> (desc_addr == {base_w, 2'b00}));
endmodule

// File: rtl/rxd_seq.sv
module rxd_seq
  import rxd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_en,
  input  logic             frm_start,
  input  logic             rx_restart,
  input  logic             jumbo,
  input  logic [1:0]       rx_offset,
  input  logic             buf_done,
  input  logic             buf_eof,
  input  logic             buf_err,
  input  logic [LEN_W-1:0] buf_len,
  input  logic [31:0]      desc_addr,
  input  logic [31:0]      stat_addr,
  input  logic [DW-1:0]    stat_word,
  input  logic             mem_ack,
  input  logic [DW-1:0]    mem_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             buf_valid,
  output logic [31:0]      buf_addr,
  output logic             bna,
  output logic             step,
  output logic             wrap,
  output logic             st_sof,
  output logic             st_eof,
  output logic             st_jumbo,
  output logic [1:0]       st_off,
  output logic [LEN_W-1:0] st_len
);
  seq_e          state;
  logic [DW-1:0] desc_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      desc_word <= '0;
      bna       <= 1'b0;
      st_sof    <= 1'b0;
      st_eof    <= 1'b0;
      st_jumbo  <= 1'b0;
      st_off    <= '0;
      st_len    <= '0;
    end else begin
      bna <= 1'b0;
      case (state)
        S_IDLE: if (rx_en && frm_start) begin
          state  <= S_FETCH;
          st_sof <= 1'b1;
        end
        S_FETCH: if (mem_ack) begin
          desc_word <= mem_rdata;
          if (mem_rdata[OWN_BIT]) begin
            state <= S_STALL;
            bna   <= 1'b1;
          end else begin
            state <= S_BUSY;
          end
        end
        S_STALL: if (rx_restart) state <= S_FETCH;
        S_BUSY: if (buf_done) begin
          if (buf_err) begin
            state <= S_IDLE;
          end else begin
            st_eof   <= buf_eof;
            st_len   <= buf_len;
            st_jumbo <= jumbo;
            st_off   <= rx_offset;
            state    <= S_WSTAT;
          end
        end
        S_WSTAT: if (mem_ack) state <= S_WOWN;
        S_WOWN: if (mem_ack) begin
          st_sof <= 1'b0;
          state  <= st_eof ? S_IDLE : S_FETCH;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = (state == S_FETCH) || (state == S_WSTAT) || (state == S_WOWN);
    mem_we    = (state == S_WSTAT) || (state == S_WOWN);
    mem_addr  = (state == S_WSTAT) ? stat_addr : desc_addr;
    mem_wdata = '0;
    if (state == S_WSTAT)     mem_wdata = stat_word;
    else if (state == S_WOWN) mem_wdata = desc_word | DW'(1);
  end

  assign buf_valid = (state == S_BUSY);
  assign buf_addr  = {desc_word[31:2], 2'b00};
  assign step      = (state == S_WOWN) && mem_ack;
  assign wrap      = desc_word[WRAP_BIT];

  // R13
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));
  // R4
  bna_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    bna |=> !bna);
  // R4
  bna_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bna) |-> $past(mem_req && mem_ack && !mem_we && mem_rdata[OWN_BIT]));
  // R5
  bv_excl_chk: assert property (@(posedge clk) disable iff (rst)
    buf_valid |-> !mem_req);
endmodule

// File: rtl/rxd_ring_mgr.sv
module rxd_ring_mgr
  import rxd_pkg::*;
#(
  parameter int CNT_W      = 11,
  parameter int DESC_WORDS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_en,
  input  logic             base_wr,
  input  logic [29:0]      base_val,
  input  logic             jumbo,
  input  logic [1:0]       rx_offset,
  input  logic             frm_start,
  input  logic             rx_restart,
  output logic             buf_valid,
  output logic [31:0]      buf_addr,
  input  logic             buf_done,
  input  logic             buf_eof,
  input  logic             buf_err,
  input  logic [LEN_W-1:0] buf_len,
  output logic             bna,
  output logic [31:0]      qptr,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_ack,
  input  logic [DW-1:0]    mem_rdata
);
  logic             step, wrap;
  logic [31:0]      stat_addr;
  logic [DW-1:0]    stat_word;
  logic             st_sof, st_eof, st_jumbo;
  logic [1:0]       st_off;
  logic [LEN_W-1:0] st_len;

  rxd_ring_ptr #(.CNT_W(CNT_W), .DESC_WORDS(DESC_WORDS)) u_ptr (
    .clk(clk), .rst(rst),
    .load(base_wr && !rx_en), .load_val(base_val),
    .step(step), .wrap(wrap),
    .desc_addr(qptr), .stat_addr(stat_addr)
  );

  rxd_status_fmt u_fmt (
    .sof(st_sof), .eof(st_eof), .jumbo(st_jumbo),
    .offset(st_off), .len(st_len), .word(stat_word)
  );

  rxd_seq u_seq (
    .clk(clk), .rst(rst), .rx_en(rx_en), .frm_start(frm_start),
    .rx_restart(rx_restart), .jumbo(jumbo), .rx_offset(rx_offset),
    .buf_done(buf_done), .buf_eof(buf_eof), .buf_err(buf_err), .buf_len(buf_len),
    .desc_addr(qptr), .stat_addr(stat_addr), .stat_word(stat_word),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .buf_valid(buf_valid), .buf_addr(buf_addr), .bna(bna),
    .step(step), .wrap(wrap),
    .st_sof(st_sof), .st_eof(st_eof), .st_jumbo(st_jumbo), .st_off(st_off), .st_len(st_len)
  );

  // R11
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (buf_valid && buf_done && buf_err && !base_wr) |=> ($stable(qptr) && !mem_we));
endmodule

// File: tb/tb_rxd_ring_mgr.sv
module tb_rxd_ring_mgr;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_en = 0, base_wr = 0, jumbo = 0, frm_start = 0, rx_restart = 0;
  logic [29:0] base_val = '0;
  logic [1:0]  rx_offset = 2'd1;
  logic buf_done = 0, buf_eof = 0, buf_err = 0;
  logic [13:0] buf_len = '0;
  logic mem_ack = 0;
  logic [31:0] mem_rdata = '0;
  logic buf_valid, bna, mem_req, mem_we;
  logic [31:0] buf_addr, qptr, mem_addr, mem_wdata;

  always #4 clk = ~clk;

  rxd_ring_mgr dut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .base_wr(base_wr), .base_val(base_val),
    .jumbo(jumbo), .rx_offset(rx_offset), .frm_start(frm_start), .rx_restart(rx_restart),
    .buf_valid(buf_valid), .buf_addr(buf_addr), .buf_done(buf_done), .buf_eof(buf_eof),
    .buf_err(buf_err), .buf_len(buf_len), .bna(bna), .qptr(qptr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int errors = 0, checks = 0, cycles = 0;
  logic [31:0] mem [0:4095];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // memory responder: one-cycle ack per request
  always @(negedge clk) begin
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req && !rst) begin
      if (mem_we) mem[mem_addr[13:2]] = mem_wdata;
      else mem_rdata <= mem[mem_addr[13:2]];
      mem_ack <= 1'b1;
    end
  end

  // behavioural reference model
  int ms = 0;
  int unsigned mbase = 0, mcnt = 0, mword = 0, mlen = 0;
  bit msof = 0, meof = 0, mbna = 0, mjum = 0;
  bit [1:0] moff = 0;
  always @(posedge clk) begin
    if (rst) begin
      ms = 0; mbase = 0; mcnt = 0; mword = 0; msof = 0; meof = 0; mbna = 0; mlen = 0;
    end else begin
      mbna = 0;
      case (ms)
        0: if (rx_en && frm_start) begin ms = 1; msof = 1; end
        1: if (mem_ack) begin
             mword = mem_rdata;
             if (mem_rdata[0]) begin ms = 2; mbna = 1; end else ms = 3;
           end
        2: if (rx_restart) ms = 1;
        3: if (buf_done) begin
             if (buf_err) ms = 0;
             else begin meof = buf_eof; mlen = buf_len; mjum = jumbo; moff = rx_offset; ms = 4; end
           end
        4: if (mem_ack) ms = 5;
        5: if (mem_ack) begin
             mcnt = mword[1] ? 0 : (mcnt + 2) % 2048;
             msof = 0;
             ms = meof ? 0 : 1;
           end
        default: ms = 0;
      endcase
      if (base_wr && !rx_en) begin mbase = {base_val, 2'b00}; mcnt = 0; end
    end
  end

  function automatic logic [31:0] mstat();
    logic [31:0] w = 0;
    w[15] = meof; w[14] = msof;
    if (mjum) w[13:12] = meof ? mlen[13:12] : 2'b00; else w[13:12] = moff;
    if (meof) w[11:0] = mlen[11:0];
    return w;
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      logic [31:0] eq, ea, ed;
      eq = mbase + mcnt * 4;
      ea = (ms == 4) ? eq + 4 : eq;
      ed = (ms == 4) ? mstat() : (ms == 5) ? (mword | 32'd1) : 32'd0;
      chk(qptr == eq, "R9/R10 qptr", qptr, eq);
      chk(mem_req == (ms == 1 || ms == 4 || ms == 5), "R13 mem_req", {31'd0, mem_req}, ms);
      chk(buf_valid == (ms == 3), "R5 buf_valid", {31'd0, buf_valid}, ms);
      chk(bna == mbna, "R4 bna", {31'd0, bna}, {31'd0, mbna});
      if (ms == 1 || ms == 4 || ms == 5) begin
        chk(mem_we == (ms != 1), "R3 mem_we", {31'd0, mem_we}, ms);
        chk(mem_addr == ea, "R6 mem_addr", mem_addr, ea);
        if (ms != 1) chk(mem_wdata == ed, "R6/R8 mem_wdata", mem_wdata, ed);
      end
      if (ms == 3) chk(buf_addr == (mword & ~32'd3), "R5 buf_addr", buf_addr, mword & ~32'd3);
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
      summary();
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_desc(input int unsigned a, input int idx, input bit wr, input bit own);
    mem[a[13:2]] = 32'hA000_0000 + (idx << 8) + {30'd0, wr, own};
    mem[(a + 4) >> 2] = 32'h0;
  endtask

  task automatic load_base(input int unsigned a);
    @(negedge clk); base_val = a[31:2]; base_wr = 1;
    @(negedge clk); base_wr = 0;
  endtask

  task automatic start();
    @(negedge clk); frm_start = 1;
    @(negedge clk); frm_start = 0;
  endtask

  task automatic do_buf(input bit eof, input int len, input bit err);
    int n = 0;
    while (!buf_valid && n < 50) begin @(negedge clk); n++; end
    chk(buf_valid, "R5 buffer offered", {31'd0, buf_valid}, 1);
    buf_done = 1; buf_eof = eof; buf_len = len[13:0]; buf_err = err;
    @(negedge clk); buf_done = 0; buf_eof = 0; buf_err = 0;
  endtask

  initial begin
    cyc(3);
    // R1 reset state
    chk(!mem_req && !buf_valid && !bna && qptr == 0, "R1 reset", qptr, 0);
    @(negedge clk); rst = 0;
    chk(qptr == 0 && !mem_req, "R1 after release", qptr, 0);

    put_desc(32'h100, 0, 0, 0);
    put_desc(32'h108, 1, 0, 0);
    put_desc(32'h110, 2, 1, 0);
    load_base(32'h100);
    chk(qptr == 32'h100, "R2 base load", qptr, 32'h100);

    // R3: frame start ignored while disabled
    start(); cyc(4);
    chk(!mem_req && !buf_valid, "R3 ignored while off", {31'd0, mem_req}, 0);

    @(negedge clk); rx_en = 1;
    load_base(32'h400);
    chk(qptr == 32'h100, "R2 load ignored while on", qptr, 32'h100);

    // single-buffer frame
    start(); do_buf(1, 100, 0); cyc(8);
    chk(mem[32'h104 >> 2] == 32'h0000_D064, "R6 status single", mem[32'h104 >> 2], 32'h0000_D064);
    chk(mem[32'h100 >> 2] == 32'hA000_0001, "R8 own write-back", mem[32'h100 >> 2], 32'hA000_0001);
    chk(qptr == 32'h108, "R9 advance", qptr, 32'h108);

    // R11: error buffer reclaimed
    start(); do_buf(0, 0, 1); cyc(8);
    chk(qptr == 32'h108, "R11 qptr kept", qptr, 32'h108);
    chk(mem[32'h10C >> 2] == 0, "R11 no status", mem[32'h10C >> 2], 0);
    chk(mem[32'h108 >> 2] == 32'hA000_0100, "R11 still hw-owned", mem[32'h108 >> 2], 32'hA000_0100);

    // R12: two-buffer frame, wrap on second
    start(); do_buf(0, 0, 0);
    do_buf(1, 300, 0); cyc(8);
    chk(mem[32'h10C >> 2] == 32'h0000_5000, "R6 R11 first-buffer sof", mem[32'h10C >> 2], 32'h0000_5000);
    chk(mem[32'h114 >> 2] == 32'h0000_912C, "R12 last-buffer status", mem[32'h114 >> 2], 32'h0000_912C);
    chk(mem[32'h110 >> 2] == 32'hA000_0203, "R8 wrap bit kept", mem[32'h110 >> 2], 32'hA000_0203);
    chk(qptr == 32'h100, "R9 wrap to base", qptr, 32'h100);

    // R4: descriptor 0 still software-owned
    begin
      int seen = 0;
      @(negedge clk); jumbo = 1; frm_start = 1;
      @(negedge clk); frm_start = 0;
      for (int i = 0; i < 10; i++) begin
        if (bna) seen++;
        if (buf_valid) seen += 100;
        @(negedge clk);
      end
      chk(seen == 1, "R4 one bna pulse, no buffer", seen, 1);
    end
    mem[32'h100 >> 2] = 32'hA000_0000;
    @(negedge clk); rx_restart = 1;
    @(negedge clk); rx_restart = 0;
    do_buf(1, 32'h2345, 0); cyc(8);
    chk(mem[32'h104 >> 2] == 32'h0000_E345, "R7 jumbo length", mem[32'h104 >> 2], 32'h0000_E345);
    chk(qptr == 32'h108, "R4 retry used same slot", qptr, 32'h108);
    @(negedge clk); jumbo = 0;

    // R10: 1024 descriptors without wrap roll over
    @(negedge clk); rx_en = 0;
    for (int i = 0; i < 1024; i++) put_desc(32'h1000 + i * 8, i, 0, 0);
    load_base(32'h1000);
    @(negedge clk); rx_en = 1;
    for (int i = 0; i < 1024; i++) begin
      start(); do_buf(1, 64, 0); cyc(6);
      if (i == 1022) chk(qptr == 32'h2FF8, "R10 last slot", qptr, 32'h2FF8);
    end
    chk(qptr == 32'h1000, "R10 rollover to base", qptr, 32'h1000);
    chk(mem[32'h2FFC >> 2] == 32'h0000_D040, "R10 last status", mem[32'h2FFC >> 2], 32'h0000_D040);

    cyc(4);
    summary();
  end
endmodule